// File: doc/BRIEF.md
# Single-Cell Charge Cycle Sequencer

This block is the digital sequencer of a single-cell lithium-ion linear charger. It takes the analog comparator results (battery above the short threshold, above the low-voltage threshold, above the recharge threshold, at the regulation voltage, and charge current under the termination level), the flags that say a regulation loop is limiting current, a thermistor-in-window flag, the charge-enable pin (active low) and the input-power-good flag. From these it steps a cell through four charging phases in order: short check, precharge, fast charge and constant voltage. It then finishes the cycle and watches the cell for a recharge.

After termination it runs an automatic battery-presence routine. When the cell sags below the recharge level, a small detect current is applied for a fixed window. If the cell holds above the low threshold, a recharge starts. If it falls, precharge current is applied for the same window. The result then decides between a new cycle and "battery missing", and a missing battery makes the routine repeat.

The status output drives an open-drain status pin. It pulls low only during the first cycle after a power-up or an enable toggle, stays released through recharges, and blinks when a safety timer has expired. The detect window and the blink half-period come from a prescaled tick counter on the system clock. The safety timers themselves live outside the block: it receives their expiry flags and tells them when to run.

Top module: `chg_seq_ctrl`

## Requirements
- R1: After reset, and whenever `pwr_ok` is low, `phase` is 0 (idle), `cur_sel` is 0 (off), `det_en` is 0 and `chg_pull` is 0. Enable is ignored while power is absent, and losing power returns the block to idle on the next clock.
- R2: From idle with power good and `en_n` low, the block enters `phase` 1 (short check) with `cur_sel` 1. It stays there until `bat_gt_short` is high, and then moves to `phase` 2 (precharge, `cur_sel` 2).
- R3: Precharge moves to `phase` 3 (fast, `cur_sel` 3) on `bat_gt_lowv`. Fast falls back to precharge if `bat_gt_lowv` drops. Fast moves to `phase` 4 (constant voltage, `cur_sel` 4) on `bat_at_reg`.
- R4: Constant voltage moves to `phase` 5 (done, `cur_sel` 0) only when `i_below_term` is high, every bit of `loop_limit` is 0 and `term_dis` is 0.
- R5: In done, `bat_gt_rch` low moves the block to `phase` 6 (probe, `det_en` 1, `cur_sel` 0). If `bat_gt_lowv` stays high, the probe lasts exactly PRESCALE×DET_TICKS cycles and then enters precharge (recharge).
- R6: `bat_gt_lowv` low during a probe moves the block at once to `phase` 7 (presence precharge, `cur_sel` 2, `det_en` 0) for PRESCALE×DET_TICKS cycles. It then goes to short check if `bat_gt_rch` is low, or back to probe if `bat_gt_rch` is high.
- R7: `chg_pull` goes to 1 on the cycle that short check passes and goes to 0 at termination. It stays 0 through recharges and new presence-triggered cycles until `en_n` goes high or `pwr_ok` goes low.
- R8: While `ts_ok` is low in phases 1 to 4, `cur_sel` is 0, `tmr_run` is 0, the phase is held and `chg_pull` is unchanged.
- R9: `pre_tmr_exp` in precharge, or `fast_tmr_exp` in fast or constant voltage, moves the block to `phase` 8 (fault, `cur_sel` 0). There `chg_pull` is 1 on entry and toggles every PRESCALE×FLASH_TICKS cycles. The fault persists until `en_n` goes high.
- R10: With `term_dis` high, constant voltage is held indefinitely, timer expiry flags are ignored and `tmr_run` is 0. `chg_pull` goes to 0 on the clock after `i_below_term` is seen in constant voltage.
- R11: `en_n` high moves the block to idle with `chg_pull` 0 on the next clock from any phase. `en_n` low again starts a new first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_ok | input | 1 | Input supply within valid window |
| en_n | input | 1 | Charge enable, active low |
| bat_gt_short | input | 1 | Battery above short-circuit threshold |
| bat_gt_lowv | input | 1 | Battery above low-voltage threshold |
| bat_gt_rch | input | 1 | Battery above recharge threshold |
| bat_at_reg | input | 1 | Battery at regulation voltage |
| i_below_term | input | 1 | Charge current below termination level |
| loop_limit | input | N_LOOPS | Thermal, load-sharing, low-input loop active flags |
| ts_ok | input | 1 | Pack thermistor inside window |
| term_dis | input | 1 | Termination disabled |
| pre_tmr_exp | input | 1 | Precharge safety timer expired |
| fast_tmr_exp | input | 1 | Fast-charge safety timer expired |
| phase | output | 4 | Current phase code |
| cur_sel | output | 3 | Current source selection for analog loop |
| det_en | output | 1 | Detect current enable |
| tmr_run | output | 1 | Safety timers may count |
| chg_pull | output | 1 | Pull status pin low |

## Verification
The hardest situation to reach is the presence routine's second branch: the cell must be terminated, drop below recharge, fall below the low threshold mid-probe, and then show either outcome at the end of the presence window. The bench walks a full cycle to done, toggles the comparator inputs at chosen cycles inside each window, and covers both the "missing, probe again" loop and the "new cycle" exit. At each exit it checks the window length to the cycle and confirms the status pin stays released. The termination gate is swept over every non-zero loop-limit pattern before it is opened.

// File: rtl/chg_seq_pkg.sv
// Package: shared phase and current-select encodings for the charge sequencer.
// Assumes: codes are visible at the top-level ports and must stay stable.
package chg_seq_pkg;

    typedef enum logic [3:0] {
        PH_IDLE  = 4'd0,
        PH_SHORT = 4'd1,
        PH_PRE   = 4'd2,
        PH_FAST  = 4'd3,
        PH_CV    = 4'd4,
        PH_DONE  = 4'd5,
        PH_PROBE = 4'd6,
        PH_DPRE  = 4'd7,
        PH_FAULT = 4'd8
    } chg_phase_e;

    typedef enum logic [2:0] {
        CUR_OFF   = 3'd0,
        CUR_SHORT = 3'd1,
        CUR_PRE   = 3'd2,
        CUR_FAST  = 3'd3,
        CUR_CV    = 3'd4
    } chg_cur_e;

endpackage

// File: rtl/chg_tick_timer.sv
// Module: prescaled interval timer. Counts PRESCALE clocks per tick and
// TICKS ticks per interval, and pulses expire on the last cycle of each
// interval, reloading while run stays high.
// Assumes: start clears the count; run low holds the count at zero.
module chg_tick_timer #(
    parameter int PRESCALE = 1000,
    parameter int TICKS    = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expire
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [PW-1:0] PRE_LAST  = PW'(PRESCALE - 1);
    localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);

    logic [PW-1:0] pre_q;
    logic [TW-1:0] tick_q;
    logic          pre_wrap;
    logic          tick_wrap;

    assign pre_wrap  = (pre_q == PRE_LAST);
    assign tick_wrap = (tick_q == TICK_LAST);
    assign expire    = run && pre_wrap && tick_wrap;

    // Advance prescaler and tick counter; clear on start or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || start || !run) begin
            pre_q  <= '0;
            tick_q <= '0;
        end else if (pre_wrap) begin
            pre_q  <= '0;
            tick_q <= tick_wrap ? '0 : tick_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/chg_phase_fsm.sv
// Module: phase state machine of the charge sequencer. Decides the next
// phase from comparator flags, enable, power and timer expiries, and
// decodes the current selection, detect enable and timer run permission.
// Assumes: all inputs are already synchronous to clk.
module chg_phase_fsm
    import chg_seq_pkg::*;
#(
    parameter int N_LOOPS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               en_n,
    input  logic               bat_gt_short,
    input  logic               bat_gt_lowv,
    input  logic               bat_gt_rch,
    input  logic               bat_at_reg,
    input  logic               i_below_term,
    input  logic [N_LOOPS-1:0] loop_limit,
    input  logic               ts_ok,
    input  logic               term_dis,
    input  logic               pre_tmr_exp,
    input  logic               fast_tmr_exp,
    input  logic               det_expire,
    output chg_phase_e         phase_q,
    output chg_cur_e           cur_sel,
    output logic               det_en,
    output logic               tmr_run,
    output logic               det_start,
    output logic               det_run,
    output logic               short_pass,
    output logic               term_evt,
    output logic               fault_entry,
    output logic               in_fault
);
    chg_phase_e phase_d;
    logic       abort;
    logic       charging;
    logic       loops_quiet;
    logic       pre_fault;
    logic       fast_fault;

    assign abort       = !pwr_ok || en_n;
    assign charging    = (phase_q == PH_SHORT) || (phase_q == PH_PRE) ||
                         (phase_q == PH_FAST)  || (phase_q == PH_CV);
    assign loops_quiet = (loop_limit == '0);
    assign pre_fault   = pre_tmr_exp && !term_dis;
    assign fast_fault  = fast_tmr_exp && !term_dis;

    // Next-phase selection; abort and thermistor hold take priority.
    always_comb begin
        phase_d = phase_q;
        if (abort) begin
            phase_d = PH_IDLE;
        end else if (charging && !ts_ok) begin
            phase_d = phase_q;
        end else begin
            case (phase_q)
                PH_IDLE:  phase_d = PH_SHORT;
                PH_SHORT: if (bat_gt_short) phase_d = PH_PRE;
                PH_PRE: begin
                    if (pre_fault)        phase_d = PH_FAULT;
                    else if (bat_gt_lowv) phase_d = PH_FAST;
                end
                PH_FAST: begin
                    if (fast_fault)        phase_d = PH_FAULT;
                    else if (!bat_gt_lowv) phase_d = PH_PRE;
                    else if (bat_at_reg)   phase_d = PH_CV;
                end
                PH_CV: begin
                    if (fast_fault)
                        phase_d = PH_FAULT;
                    else if (i_below_term && loops_quiet && !term_dis)
                        phase_d = PH_DONE;
                end
                PH_DONE:  if (!bat_gt_rch) phase_d = PH_PROBE;
                PH_PROBE: begin
                    if (!bat_gt_lowv)    phase_d = PH_DPRE;
                    else if (det_expire) phase_d = PH_PRE;
                end
                PH_DPRE: begin
                    if (det_expire) phase_d = bat_gt_rch ? PH_PROBE : PH_SHORT;
                end
                PH_FAULT: phase_d = PH_FAULT;
                default:  phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Current-source selection; charging phases go dark out of thermistor window.
    always_comb begin
        cur_sel = CUR_OFF;
        case (phase_q)
            PH_SHORT: cur_sel = ts_ok ? CUR_SHORT : CUR_OFF;
            PH_PRE:   cur_sel = ts_ok ? CUR_PRE   : CUR_OFF;
            PH_FAST:  cur_sel = ts_ok ? CUR_FAST  : CUR_OFF;
            PH_CV:    cur_sel = ts_ok ? CUR_CV    : CUR_OFF;
            PH_DPRE:  cur_sel = CUR_PRE;
            default:  cur_sel = CUR_OFF;
        endcase
    end

    // Event strobes toward the timers and the status logic.
    always_comb begin
        det_en      = (phase_q == PH_PROBE);
        det_run     = (phase_q == PH_PROBE) || (phase_q == PH_DPRE);
        det_start   = (phase_d != phase_q) &&
                      ((phase_d == PH_PROBE) || (phase_d == PH_DPRE));
        tmr_run     = ts_ok && !term_dis &&
                      ((phase_q == PH_PRE) || (phase_q == PH_FAST) || (phase_q == PH_CV));
        short_pass  = (phase_q == PH_SHORT) && (phase_d == PH_PRE);
        term_evt    = ((phase_q == PH_CV) && (phase_d == PH_DONE)) ||
                      ((phase_q == PH_CV) && term_dis && ts_ok && i_below_term && !abort);
        fault_entry = (phase_d == PH_FAULT) && (phase_q != PH_FAULT);
        in_fault    = (phase_q == PH_FAULT);
    end
endmodule

// File: rtl/chg_status_out.sv
// Module: status pin control. Tracks whether the current first cycle has
// passed short check and whether it has terminated, and blinks in fault.
// Assumes: flags clear on enable release or power loss; blink toggles on
// each flash timer expiry.
module chg_status_out (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic en_n,
    input  logic short_pass,
    input  logic term_evt,
    input  logic fault_entry,
    input  logic in_fault,
    input  logic flash_expire,
    output logic chg_pull
);
    logic cycle_q;
    logic done_q;
    logic blink_q;
    logic rearm;

    assign rearm = !pwr_ok || en_n;

    // First-cycle flag: set when short check passes.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm)  cycle_q <= 1'b0;
        else if (short_pass)  cycle_q <= 1'b1;
    end

    // Termination flag: once set, keeps the pin released through recharges.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm) done_q <= 1'b0;
        else if (term_evt)   done_q <= 1'b1;
    end

    // Blink phase: starts pulled on fault entry, toggles per flash interval.
    always_ff @(posedge clk) begin
        if (!rst_n || rearm)            blink_q <= 1'b0;
        else if (fault_entry)           blink_q <= 1'b1;
        else if (in_fault && flash_expire) blink_q <= ~blink_q;
    end

    assign chg_pull = in_fault ? blink_q : (cycle_q && !done_q);
endmodule

// File: rtl/chg_seq_ctrl.sv
// Module: top of the charge cycle sequencer. Connects the phase machine,
// the presence-detect window timer, the fault blink timer and the status
// pin control.
// Assumes: PRESCALE clocks form one tick; DET_TICKS and FLASH_TICKS give
// the detect window and the blink half-period in ticks.
module chg_seq_ctrl
    import chg_seq_pkg::*;
#(
    parameter int PRESCALE    = 1000,
    parameter int DET_TICKS   = 250,
    parameter int FLASH_TICKS = 250,
    parameter int N_LOOPS     = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_ok,
    input  logic               en_n,
    input  logic               bat_gt_short,
    input  logic               bat_gt_lowv,
    input  logic               bat_gt_rch,
    input  logic               bat_at_reg,
    input  logic               i_below_term,
    input  logic [N_LOOPS-1:0] loop_limit,
    input  logic               ts_ok,
    input  logic               term_dis,
    input  logic               pre_tmr_exp,
    input  logic               fast_tmr_exp,
    output logic [3:0]         phase,
    output logic [2:0]         cur_sel,
    output logic               det_en,
    output logic               tmr_run,
    output logic               chg_pull
);
    chg_phase_e phase_q;
    chg_cur_e   cur_q;
    logic det_start, det_run, det_expire;
    logic short_pass, term_evt, fault_entry, in_fault, flash_expire;

    chg_phase_fsm #(.N_LOOPS(N_LOOPS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en_n(en_n),
        .bat_gt_short(bat_gt_short), .bat_gt_lowv(bat_gt_lowv),
        .bat_gt_rch(bat_gt_rch), .bat_at_reg(bat_at_reg),
        .i_below_term(i_below_term), .loop_limit(loop_limit),
        .ts_ok(ts_ok), .term_dis(term_dis),
        .pre_tmr_exp(pre_tmr_exp), .fast_tmr_exp(fast_tmr_exp),
        .det_expire(det_expire), .phase_q(phase_q), .cur_sel(cur_q),
        .det_en(det_en), .tmr_run(tmr_run), .det_start(det_start),
        .det_run(det_run), .short_pass(short_pass), .term_evt(term_evt),
        .fault_entry(fault_entry), .in_fault(in_fault)
    );

    chg_tick_timer #(.PRESCALE(PRESCALE), .TICKS(DET_TICKS)) u_det_tmr (
        .clk(clk), .rst_n(rst_n), .start(det_start), .run(det_run),
        .expire(det_expire)
    );

    chg_tick_timer #(.PRESCALE(PRESCALE), .TICKS(FLASH_TICKS)) u_flash_tmr (
        .clk(clk), .rst_n(rst_n), .start(fault_entry), .run(in_fault),
        .expire(flash_expire)
    );

    chg_status_out u_status (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en_n(en_n),
        .short_pass(short_pass), .term_evt(term_evt),
        .fault_entry(fault_entry), .in_fault(in_fault),
        .flash_expire(flash_expire), .chg_pull(chg_pull)
    );

    assign phase   = phase_q;
    assign cur_sel = cur_q;
endmodule

// File: rtl/chg_seq_ctrl_chk.sv
// Module: assertion checker for the charge sequencer, attached by bind.
// Assumes: only top-level ports are observed.
module chg_seq_ctrl_chk #(
    parameter int N_LOOPS = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_ok,
    input logic               en_n,
    input logic               bat_gt_short,
    input logic               bat_gt_lowv,
    input logic               bat_gt_rch,
    input logic [N_LOOPS-1:0] loop_limit,
    input logic               ts_ok,
    input logic               term_dis,
    input logic               pre_tmr_exp,
    input logic [3:0]         phase,
    input logic [2:0]         cur_sel,
    input logic               tmr_run,
    input logic               chg_pull
);
    assert_unpowered_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> (phase == 4'd0 && !chg_pull));

    assert_short_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd1 && !bat_gt_short) |=> (phase != 4'd2));

    assert_pre_to_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd2 && bat_gt_lowv && ts_ok && pwr_ok && !en_n &&
         !(pre_tmr_exp && !term_dis)) |=> (phase == 4'd3));

    assert_term_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd4 && (loop_limit != '0 || term_dis)) |=> (phase != 4'd5));

    assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd5 && bat_gt_rch && pwr_ok && !en_n) |=> (phase == 4'd5));

    assert_probe_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd6 && !bat_gt_lowv && pwr_ok && !en_n) |=> (phase == 4'd7));

    assert_silent_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase >= 4'd5 && phase <= 4'd7) |-> !chg_pull);

    assert_ts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_ok && pwr_ok && !en_n && phase >= 4'd1 && phase <= 4'd4)
        |=> (phase == $past(phase)));

    assert_ts_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_ok && phase >= 4'd1 && phase <= 4'd4) |-> (cur_sel == 3'd0 && !tmr_run));

    assert_fault_persist_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 4'd8 && pwr_ok && !en_n) |=> (phase == 4'd8));

    assert_cv_forever_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (term_dis && phase == 4'd4 && pwr_ok && !en_n) |=> (phase == 4'd4));

    assert_enable_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (phase == 4'd0 && !chg_pull));
endmodule

bind chg_seq_ctrl chg_seq_ctrl_chk #(.N_LOOPS(N_LOOPS)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en_n(en_n),
    .bat_gt_short(bat_gt_short), .bat_gt_lowv(bat_gt_lowv),
    .bat_gt_rch(bat_gt_rch), .loop_limit(loop_limit), .ts_ok(ts_ok),
    .term_dis(term_dis), .pre_tmr_exp(pre_tmr_exp), .phase(phase),
    .cur_sel(cur_sel), .tmr_run(tmr_run), .chg_pull(chg_pull)
);

// File: tb/chg_seq_ctrl_tb.sv
// Bench: walks the sequencer through every phase with a small prescaler,
// computing window lengths and blink pattern from the parameters.
module chg_seq_ctrl_tb;
    localparam int P  = 4;
    localparam int DT = 3;
    localparam int FT = 2;
    localparam int PN = P * DT;
    localparam int PH = P * FT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_ok = 1'b0, en_n = 1'b1;
    logic bat_gt_short = 1'b0, bat_gt_lowv = 1'b0, bat_gt_rch = 1'b0, bat_at_reg = 1'b0;
    logic i_below_term = 1'b0;
    logic [2:0] loop_limit = 3'd0;
    logic ts_ok = 1'b1, term_dis = 1'b0, pre_tmr_exp = 1'b0, fast_tmr_exp = 1'b0;
    logic [3:0] phase;
    logic [2:0] cur_sel;
    logic det_en, tmr_run, chg_pull;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    chg_seq_ctrl #(.PRESCALE(P), .DET_TICKS(DT), .FLASH_TICKS(FT), .N_LOOPS(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en_n(en_n),
        .bat_gt_short(bat_gt_short), .bat_gt_lowv(bat_gt_lowv),
        .bat_gt_rch(bat_gt_rch), .bat_at_reg(bat_at_reg),
        .i_below_term(i_below_term), .loop_limit(loop_limit), .ts_ok(ts_ok),
        .term_dis(term_dis), .pre_tmr_exp(pre_tmr_exp), .fast_tmr_exp(fast_tmr_exp),
        .phase(phase), .cur_sel(cur_sel), .det_en(det_en), .tmr_run(tmr_run),
        .chg_pull(chg_pull)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 reset phase", phase, 0);
        check("R1 reset cur_sel", cur_sel, 0);
        check("R1 reset chg_pull", chg_pull, 0);
        check("R1 reset det_en", det_en, 0);

        en_n = 1'b0;
        step(3);
        check("R1 enable ignored without power", phase, 0);

        pwr_ok = 1'b1;
        step(1);
        check("R2 short check entered", phase, 1);
        step(4);
        check("R2 short check held", phase, 1);
        check("R2 short current", cur_sel, 1);
        check("R7 no pull before short pass", chg_pull, 0);

        bat_gt_short = 1'b1;
        step(1);
        check("R2 precharge after short pass", phase, 2);
        check("R2 precharge current", cur_sel, 2);
        check("R7 pull after short pass", chg_pull, 1);
        step(3);
        check("R3 precharge held below low", phase, 2);

        bat_gt_lowv = 1'b1;
        bat_gt_rch  = 1'b1;
        step(1);
        check("R3 fast entered", phase, 3);
        check("R3 fast current", cur_sel, 3);
        bat_gt_lowv = 1'b0;
        step(1);
        check("R3 fast falls back", phase, 2);
        bat_gt_lowv = 1'b1;
        step(1);
        check("R3 fast again", phase, 3);

        bat_at_reg = 1'b1;
        ts_ok = 1'b0;
        #1;
        check("R8 current off out of window", cur_sel, 0);
        check("R8 timers paused", tmr_run, 0);
        step(3);
        check("R8 phase held", phase, 3);
        check("R8 pull unchanged", chg_pull, 1);
        ts_ok = 1'b1;
        step(1);
        check("R3 constant voltage entered", phase, 4);
        check("R3 cv current", cur_sel, 4);
        check("R8 timers run in window", tmr_run, 1);

        i_below_term = 1'b1;
        for (int m = 1; m < 8; m++) begin
            loop_limit = 3'(m);
            step(2);
            check("R4 termination blocked by loop", phase, 4);
            check("R4 pull kept while blocked", chg_pull, 1);
        end
        loop_limit = 3'd0;
        step(1);
        check("R4 done entered", phase, 5);
        check("R4 done current off", cur_sel, 0);
        check("R7 released at termination", chg_pull, 0);
        i_below_term = 1'b0;

        step(5);
        check("R5 done held above recharge", phase, 5);
        bat_gt_rch = 1'b0;
        step(1);
        check("R5 probe entered", phase, 6);
        check("R5 detect current on", det_en, 1);
        step(PN - 1);
        check("R5 probe window last cycle", phase, 6);
        step(1);
        check("R5 recharge starts in precharge", phase, 2);
        check("R7 silent recharge", chg_pull, 0);
        check("R5 detect current off", det_en, 0);
        bat_gt_rch = 1'b1;
        step(1);
        check("R3 recharge fast", phase, 3);
        step(1);
        check("R3 recharge cv", phase, 4);
        check("R7 silent during recharge cv", chg_pull, 0);
        i_below_term = 1'b1;
        step(1);
        check("R4 recharge done", phase, 5);
        i_below_term = 1'b0;

        bat_gt_rch = 1'b0;
        step(1);
        check("R5 probe again", phase, 6);
        bat_gt_lowv = 1'b0;
        step(1);
        check("R6 presence precharge entered", phase, 7);
        check("R6 presence precharge current", cur_sel, 2);
        check("R6 detect current off", det_en, 0);
        bat_gt_rch = 1'b1;
        step(PN - 1);
        check("R6 presence window last cycle", phase, 7);
        step(1);
        check("R6 missing battery probes again", phase, 6);
        step(1);
        check("R6 low battery back to presence precharge", phase, 7);
        bat_gt_rch = 1'b0;
        step(PN - 1);
        check("R6 presence window held", phase, 7);
        step(1);
        check("R6 new cycle short check", phase, 1);
        check("R7 silent new cycle", chg_pull, 0);
        step(1);
        check("R6 new cycle precharge", phase, 2);
        check("R7 still released after new short pass", chg_pull, 0);

        en_n = 1'b1;
        step(1);
        check("R11 enable release idle", phase, 0);
        check("R11 enable release pull", chg_pull, 0);
        en_n = 1'b0;
        step(1);
        check("R11 restart short check", phase, 1);
        step(1);
        check("R7 pull rearmed after toggle", chg_pull, 1);

        pre_tmr_exp = 1'b1;
        step(1);
        pre_tmr_exp = 1'b0;
        check("R9 fault from precharge timer", phase, 8);
        check("R9 fault current off", cur_sel, 0);
        for (int k = 0; k < 3 * PH; k++) begin
            check("R9 blink pattern", chg_pull, ((k / PH) % 2 == 0) ? 1 : 0);
            check("R9 fault persists", phase, 8);
            step(1);
        end

        en_n = 1'b1;
        step(1);
        check("R11 fault cleared by enable", phase, 0);
        en_n = 1'b0;
        step(2);
        check("R2 short passes at once", phase, 2);
        bat_gt_lowv = 1'b1;
        step(1);
        check("R3 fast before timer fault", phase, 3);
        fast_tmr_exp = 1'b1;
        step(1);
        fast_tmr_exp = 1'b0;
        check("R9 fault from fast timer", phase, 8);
        check("R9 blink starts pulled", chg_pull, 1);

        en_n = 1'b1;
        step(1);
        en_n = 1'b0;
        step(4);
        check("R3 back in cv", phase, 4);
        term_dis = 1'b1;
        #1;
        check("R10 timers stopped", tmr_run, 0);
        i_below_term = 1'b1;
        fast_tmr_exp = 1'b1;
        step(1);
        check("R10 cv held", phase, 4);
        check("R10 released below termination", chg_pull, 0);
        step(10);
        check("R10 cv held indefinitely", phase, 4);
        check("R10 expiry ignored", chg_pull, 0);
        fast_tmr_exp = 1'b0;

        pwr_ok = 1'b0;
        step(1);
        check("R1 power loss idle", phase, 0);
        check("R1 power loss pull", chg_pull, 0);
        check("R1 power loss current", cur_sel, 0);
        step(3);
        check("R1 stays idle without power", phase, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule